// File: doc/BRIEF.md
# I2C Controller Status Flags and Interrupt Vector Unit

This unit keeps the event flags of an I2C master controller, together with the interrupt enable mask and the two DMA request enables. From them it drives one interrupt line and two DMA request lines, one per transfer direction. Other parts of the controller raise individual flags with one-cycle set pulses on a 16-bit vector and present the bus-busy condition as a live level.

The host reaches the unit through a small 16-bit register port with a 3-bit word address. Status, interrupt enable, an interrupt vector and a DMA configuration register can be read. Reading the vector register returns the one-based position of the lowest pending enabled flag and clears that flag in the same access, so an interrupt handler drains pending events in a fixed priority order, one read per event. Enabling DMA for a direction turns off the interrupt enable of that direction's ready flag, so data movement and interrupts do not both react to the same flag.

A small access sequencer with two states answers reads. `HS_IDLE` is the rest state. Any accepted read moves it to `HS_RESP`, where `host_rvalid` is high and `host_rdata` holds the answer. From `HS_RESP` a further read keeps it in `HS_RESP`; otherwise it returns to `HS_IDLE`. Reset forces `HS_IDLE`.

Top module: `i2c_intr_status`

## Requirements
- R1: A synchronous reset (`rst` high) clears all flags, the interrupt enable mask and the DMA enables. It also drops `irq`, `rx_dma_req`, `tx_dma_req` and `host_rvalid`.
- R2: A set pulse on `flag_set` raises the corresponding flag at the next clock edge, and the flag stays set until it is cleared. Only bits 1 (no-acknowledge), 2 (access ready), 3 (receive ready), 4 (transmit ready), 9 (addressed as target), 10 (transmit underflow), 11 (receive overrun) and 15 (single byte) are stored. Set pulses on all other bits are ignored.
- R3: A read accepted at a clock edge drives `host_rvalid` high and returns its data on `host_rdata` after that edge. The register addresses are: status 0, interrupt enable 1, vector 2, DMA configuration 3. A status read returns the stored flags, with bit 12 replaced by the `bus_busy` level at the read edge.
- R4: A write to the interrupt enable register keeps only bits 4:0. A read returns those bits, with the upper bits zero.
- R5: `irq` is high exactly when the bitwise AND of the status flags and the interrupt enable mask is nonzero.
- R6: A vector read returns one plus the bit position of the lowest set bit of (status AND enable mask), or 0 if no such bit is set. It clears that one flag at the same edge.
- R7: When a set pulse and a vector-read clear target the same flag at the same edge, the flag stays set.
- R8: A DMA configuration write keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). If the written bit 15 is 1, enable bit 3 is cleared. If the written bit 7 is 1, enable bit 4 is cleared.
- R9: `rx_dma_req` equals receive DMA enable AND flag bit 3. `tx_dma_req` equals transmit DMA enable AND flag bit 4.
- R10: Host writes to the status and vector addresses change no state.
- R11: While `ctrl_en` is low, the flags, the enable mask and the DMA enables are held at zero, and set pulses and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_en | input | 1 | Controller enable; low clears and holds all state |
| flag_set | input | 16 | One-cycle set pulses, one per status bit position |
| bus_busy | input | 1 | Live bus-busy level, shown as status bit 12 |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Register word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid while host_rvalid is high |
| host_rvalid | output | 1 | Read response valid |
| irq | output | 1 | Interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
Set pulses, writes and the vector clear take effect at the next clock edge. `irq` and both DMA requests change just after that edge, with no further delay. A read strobe sampled at edge k produces `host_rvalid` and `host_rdata` after edge k, computed from the state before that edge, while the vector clear lands at the same edge. The bench drives inputs on falling edges and keeps a behavioural model updated on rising edges. It compares every output on each falling edge, so each result is sampled in the half cycle right after the edge that produces it. Directed reads with fixed expected values cover the priority order, the case where set and clear collide, the enable masking done by DMA writes, and the disable clear.

// File: rtl/i2c_intr_pkg.sv
package i2c_intr_pkg;

    localparam int STAT_W = 16;
    localparam int IEN_W  = 5;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam int B_NACK = 1;
    localparam int B_ARDY = 2;
    localparam int B_RRDY = 3;
    localparam int B_XRDY = 4;
    localparam int B_AAS  = 9;
    localparam int B_XUDF = 10;
    localparam int B_ROVR = 11;
    localparam int B_BUSY = 12;
    localparam int B_SBD  = 15;

    localparam int DMA_RX_BIT = 15;
    localparam int DMA_TX_BIT = 7;

    localparam logic [STAT_W-1:0] STAT_KEEP =
        (STAT_W'(1) << B_NACK) | (STAT_W'(1) << B_ARDY) |
        (STAT_W'(1) << B_RRDY) | (STAT_W'(1) << B_XRDY) |
        (STAT_W'(1) << B_AAS)  | (STAT_W'(1) << B_XUDF) |
        (STAT_W'(1) << B_ROVR) | (STAT_W'(1) << B_SBD);

    localparam logic [DATA_W-1:0] DMA_KEEP =
        (DATA_W'(1) << DMA_RX_BIT) | (DATA_W'(1) << DMA_TX_BIT);

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS = 3'd0,
        RA_IEN    = 3'd1,
        RA_VECTOR = 3'd2,
        RA_DMA    = 3'd3
    } reg_addr_e;

    typedef enum logic [0:0] {
        HS_IDLE = 1'b0,
        HS_RESP = 1'b1
    } host_state_e;

endpackage

// File: rtl/i2c_intr_prio.sv
module i2c_intr_prio #(
    parameter int W  = 16,
    parameter int IW = $clog2(W + 1)
) (
    input  logic [W-1:0]  pend,
    output logic [W-1:0]  lowest,
    output logic [IW-1:0] idx
);
    // isolate lowest set bit
    assign lowest = pend & (~pend + W'(1));

    // one-based position; scan from top so the lowest hit is kept last
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i + 1);
        end
    end
endmodule

// File: rtl/i2c_intr_flags.sv
module i2c_intr_flags #(
    parameter int          W    = 16,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] stat_q
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            stat_q <= '0;
        end else begin
            // set applied after clear: set wins on collision
            stat_q <= ((stat_q & ~clr_vec) | set_vec) & KEEP;
        end
    end

    // R2 / R7: a stored-bit set pulse is visible after the edge
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst || !en)
        (!rst && en && ((set_vec & KEEP) != '0)) |=>
        ((stat_q & $past(set_vec & KEEP)) == $past(set_vec & KEEP)));

    // R2: flags are sticky unless cleared
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst || !en)
        (!rst && en) |=>
        (((stat_q | $past(clr_vec)) & $past(stat_q)) == $past(stat_q)));

    // R6: a vector read clears at most one flag
    a_r6_single_clear: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));
endmodule

// File: rtl/i2c_intr_host.sv
module i2c_intr_host
    import i2c_intr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int EW = IEN_W,
    parameter int SW = STAT_W,
    parameter int IW = $clog2(STAT_W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] status_view,
    input  logic [SW-1:0] vec_lowest,
    input  logic [IW-1:0] vec_idx,
    output logic [SW-1:0] clr_vec,
    output logic [EW-1:0] ien_q,
    output logic [DW-1:0] dma_q,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    host_state_e state_q, state_d;
    logic [DW-1:0] rd_mux;
    logic [EW-1:0] ien_kill;
    logic          wr_ien, wr_dma, rd_vec;

    assign wr_ien = en && wr && (addr == RA_IEN);
    assign wr_dma = en && wr && (addr == RA_DMA);
    assign rd_vec = en && rd && (addr == RA_VECTOR);

    assign clr_vec = rd_vec ? vec_lowest : '0;

    always_comb begin
        ien_kill = '0;
        ien_kill[B_RRDY] = wdata[DMA_RX_BIT];
        ien_kill[B_XRDY] = wdata[DMA_TX_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ien_q <= '0;
            dma_q <= '0;
        end else if (wr_ien) begin
            ien_q <= wdata[EW-1:0];
        end else if (wr_dma) begin
            dma_q <= wdata & DMA_KEEP;
            ien_q <= ien_q & ~ien_kill;
        end
    end

    always_comb begin
        unique case (addr)
            RA_STATUS: rd_mux = status_view;
            RA_IEN:    rd_mux = DW'(ien_q);
            RA_VECTOR: rd_mux = DW'(vec_idx);
            RA_DMA:    rd_mux = dma_q;
            default:   rd_mux = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= HS_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            HS_IDLE: state_d = rd ? HS_RESP : HS_IDLE;
            HS_RESP: state_d = rd ? HS_RESP : HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end
    assign rvalid = (state_q == HS_RESP);

    a_r3_resp_next: assert property (@(posedge clk) disable iff (rst)
        (!rst && rd) |=> rvalid);

    a_r8_rx_dma_drops_ie: assert property (@(posedge clk) disable iff (rst)
        (wr_dma && wdata[DMA_RX_BIT]) |=> !ien_q[B_RRDY]);

    a_r8_tx_dma_drops_ie: assert property (@(posedge clk) disable iff (rst)
        (wr_dma && wdata[DMA_TX_BIT]) |=> !ien_q[B_XRDY]);
endmodule

// File: rtl/i2c_intr_status.sv
module i2c_intr_status
    import i2c_intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_en,
    input  logic [STAT_W-1:0] flag_set,
    input  logic              bus_busy,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              irq,
    output logic              rx_dma_req,
    output logic              tx_dma_req
);
    localparam int IW = $clog2(STAT_W + 1);

    logic [STAT_W-1:0] stat_q, clr_vec, pend, lowest, status_view;
    logic [IEN_W-1:0]  ien_q;
    logic [DATA_W-1:0] dma_q;
    logic [IW-1:0]     vec_idx;

    i2c_intr_flags #(.W(STAT_W), .KEEP(STAT_KEEP)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_en),
        .set_vec (flag_set),
        .clr_vec (clr_vec),
        .stat_q  (stat_q)
    );

    assign pend = stat_q & STAT_W'(ien_q);

    i2c_intr_prio #(.W(STAT_W), .IW(IW)) u_prio (
        .pend   (pend),
        .lowest (lowest),
        .idx    (vec_idx)
    );

    always_comb begin
        status_view = stat_q;
        status_view[B_BUSY] = bus_busy;
    end

    i2c_intr_host #(.IW(IW)) u_host (
        .clk         (clk),
        .rst         (rst),
        .en          (ctrl_en),
        .rd          (host_rd),
        .wr          (host_wr),
        .addr        (host_addr),
        .wdata       (host_wdata),
        .status_view (status_view),
        .vec_lowest  (lowest),
        .vec_idx     (vec_idx),
        .clr_vec     (clr_vec),
        .ien_q       (ien_q),
        .dma_q       (dma_q),
        .rdata       (host_rdata),
        .rvalid      (host_rvalid)
    );

    assign irq        = |pend;
    assign rx_dma_req = dma_q[DMA_RX_BIT] & stat_q[B_RRDY];
    assign tx_dma_req = dma_q[DMA_TX_BIT] & stat_q[B_XRDY];

    // R11: disable leaves every request line low
    a_r11_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> (!irq && !rx_dma_req && !tx_dma_req));

    // R5 / R6: a vector read while irq is high yields a nonzero vector
    a_r6_vector_nonzero: assert property (@(posedge clk) disable iff (rst)
        (irq && ctrl_en && host_rd && host_addr == RA_VECTOR) |=>
        (host_rdata != '0));

    // R1: reset leaves every output low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq && !rx_dma_req && !tx_dma_req && !host_rvalid));
endmodule

// File: tb/i2c_intr_status_tb.sv
module i2c_intr_status_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_en = 1'b0;
    logic [15:0] flag_set = '0;
    logic        bus_busy = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid, irq, rx_dma_req, tx_dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_intr_status u_dut (
        .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .flag_set(flag_set),
        .bus_busy(bus_busy), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .irq(irq),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    // behavioural reference model
    logic [15:0] m_st = '0, m_ie = '0, m_dma = '0, m_rd = '0;
    logic        m_rv = 1'b0;
    localparam logic [15:0] KEEP = 16'h8E1E;

    always @(posedge clk) begin
        logic [15:0] pend, clr;
        int v;
        pend = m_st & m_ie;
        v = 0;
        for (int i = 15; i >= 0; i--) if (pend[i]) v = i + 1;
        clr = 16'h0;
        if (rst) begin
            m_rv = 1'b0;
            m_rd = '0;
        end else if (host_rd) begin
            m_rv = 1'b1;
            case (host_addr)
                3'd0: m_rd = m_st | (bus_busy ? 16'h1000 : 16'h0);
                3'd1: m_rd = m_ie;
                3'd2: m_rd = 16'(v);
                3'd3: m_rd = m_dma;
                default: m_rd = 16'h0;
            endcase
            if (host_addr == 3'd2 && v != 0) clr[v-1] = 1'b1;
        end else begin
            m_rv = 1'b0;
        end
        if (rst || !ctrl_en) begin
            m_st = '0; m_ie = '0; m_dma = '0;
        end else begin
            m_st = ((m_st & ~clr) | flag_set) & KEEP;
            if (host_wr && host_addr == 3'd1) m_ie = host_wdata & 16'h001F;
            else if (host_wr && host_addr == 3'd3) begin
                m_dma = host_wdata & 16'h8080;
                if (host_wdata[15]) m_ie[3] = 1'b0;
                if (host_wdata[7])  m_ie[4] = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // compare against model every cycle
    always @(negedge clk) begin
        if (!done) begin
            chk("R5 irq", 16'(irq), 16'(|(m_st & m_ie)));
            chk("R9 rx_dma_req", 16'(rx_dma_req), 16'(m_dma[15] & m_st[3]));
            chk("R9 tx_dma_req", 16'(tx_dma_req), 16'(m_dma[7] & m_st[4]));
            chk("R3 rvalid", 16'(host_rvalid), 16'(m_rv));
            if (m_rv) chk("R3 rdata", host_rdata, m_rd);
        end
    end

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        chk(tag, host_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] v);
        flag_set = v;
        @(negedge clk);
        flag_set = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq after reset", 16'(irq), 16'h0);
        chk("R1 rvalid after reset", 16'(host_rvalid), 16'h0);
        rst = 1'b0; ctrl_en = 1'b1;
        @(negedge clk);
        rd(3'd0, 16'h0000, "R1 status after reset");

        pulse(16'hFFFF);
        rd(3'd0, 16'h8E1E, "R2 stored flags only");
        bus_busy = 1'b1;
        rd(3'd0, 16'h9E1E, "R3 busy bit 12");
        bus_busy = 1'b0;

        wr(3'd1, 16'hFFFF);
        rd(3'd1, 16'h001F, "R4 enable width");
        chk("R5 irq high", 16'(irq), 16'h1);

        rd(3'd2, 16'd2, "R6 vector nack");
        rd(3'd2, 16'd3, "R6 vector ardy");
        rd(3'd2, 16'd4, "R6 vector rrdy");
        rd(3'd2, 16'd5, "R6 vector xrdy");
        rd(3'd2, 16'd0, "R6 vector empty");
        rd(3'd0, 16'h8E00, "R6 four flags cleared");
        chk("R5 irq low", 16'(irq), 16'h0);

        wr(3'd0, 16'h0000);
        wr(3'd2, 16'h0000);
        rd(3'd0, 16'h8E00, "R10 status write ignored");

        pulse(16'h0002);
        flag_set = 16'h0002;
        rd(3'd2, 16'd2, "R7 vector during set");
        flag_set = '0;
        rd(3'd0, 16'h8E02, "R7 set wins");

        wr(3'd1, 16'h001F);
        wr(3'd3, 16'hFFFF);
        rd(3'd3, 16'h8080, "R8 dma keep bits");
        rd(3'd1, 16'h0007, "R8 ready enables dropped");
        pulse(16'h0018);
        chk("R9 rx request", 16'(rx_dma_req), 16'h1);
        chk("R9 tx request", 16'(tx_dma_req), 16'h1);
        wr(3'd3, 16'h0000);
        chk("R9 rx request off", 16'(rx_dma_req), 16'h0);
        rd(3'd1, 16'h0007, "R8 zero write keeps enables");

        ctrl_en = 1'b0;
        pulse(16'h0002);
        ctrl_en = 1'b1;
        rd(3'd0, 16'h0000, "R11 flags cleared");
        rd(3'd1, 16'h0000, "R11 enables cleared");
        rd(3'd3, 16'h0000, "R11 dma cleared");
        chk("R11 irq low", 16'(irq), 16'h0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule